// File: doc/BRIEF.md
# Character Bank Register File with Nibble Writes

This block keeps eight 8-bit bank numbers for a character (pattern) memory and turns a 13-bit video address into a physical character-memory address. Video address bits 12:10 pick one of the eight registers. The chosen 8-bit bank number is placed above video address bits 9:0, which gives an 18-bit address into 1 KB pages.

The CPU loads the registers over a write port of 16-bit address, 8-bit data and a strobe. Each write carries only four bits: it updates either the low or the high half of a single register. The address is first ANDed with 0xF0CF. The top nibble of the result picks a pair of registers, and the low byte picks which half of which member of the pair is written. Several offsets are aliases for the same half.

The lookup path is purely combinational from the register contents. A write becomes visible on the output after the next rising clock edge.

Top module: `chrbank_top`

## Requirements
- R1: While reset is low, and just after it is released, register k holds the value k for every k from 0 to 7.
- R2: `chr_addr` always equals `{register[vid_addr[12:10]], vid_addr[9:0]}` and follows `vid_addr` within the same cycle.
- R3: The write address is ANDed with 0xF0CF before it is decoded. Masked top nibble 0xB selects registers 0 and 1, 0xC selects 2 and 3, 0xD selects 4 and 5, and 0xE selects 6 and 7, with the even register first. Address bits 11:8 and 5:4 have no effect.
- R4: Masked low offset 0x000 writes bits 3:0 of the even register of the pair.
- R5: Masked low offsets 0x002 and 0x040 write bits 7:4 of the even register.
- R6: Masked low offsets 0x001, 0x004 and 0x080 write bits 3:0 of the odd register.
- R7: Masked low offsets 0x003, 0x006 and 0x0C0 write bits 7:4 of the odd register.
- R8: A write stores only `cpu_data[3:0]`. It leaves the other half of the target register and all other registers unchanged, and `cpu_data[7:4]` is ignored.
- R9: Any other masked offset, and any masked top nibble outside 0xB to 0xE, changes no register.
- R10: A write takes effect at the rising edge at which `cpu_we` is high. With `cpu_we` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data; only bits 3:0 are used |
| vid_addr | input | 13 | Video character address |
| chr_addr | output | 18 | Physical character address: bank number above vid_addr[9:0] |

## Verification
On every cycle, the embedded assertions check the merge rules. A low-half write must keep the high half and store the data's low four bits, and the same holds with the halves swapped. Every register that was not addressed must stay unchanged. A decode hit must come only from an enabled write inside the four register regions.

Which alias lands in which register cannot be checked by a property. The same is true of ignoring the masked-out address bits and of the reset values seen at the output. The bench shows these by sweeping every low address byte in every top-nibble region and reading all eight banks back through `chr_addr`.

// File: rtl/chrbank_pkg.sv
package chrbank_pkg;

    localparam int CPU_AW = 16;
    localparam logic [CPU_AW-1:0] CPU_ADDR_MASK = 16'hF0CF;

    typedef enum logic [1:0] {
        NIB_NONE = 2'd0,
        NIB_LOW  = 2'd1,
        NIB_HIGH = 2'd2
    } nib_sel_e;

endpackage

// File: rtl/chrbank_decode.sv
module chrbank_decode
    import chrbank_pkg::*;
#(
    parameter int           SEL_W       = 3,
    parameter logic [3:0]   REGION_BASE = 4'hB
) (
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [SEL_W-1:0]  wr_idx,
    output nib_sel_e          wr_nib
);

    localparam int NUM_PAIRS = (1 << SEL_W) / 2;

    logic [CPU_AW-1:0] masked;
    logic [3:0]        region;
    logic [3:0]        rel;
    logic              in_window;
    logic [5:0]        offs;
    logic              odd_sel;
    nib_sel_e          nib_raw;

    always_comb begin
        masked    = cpu_addr & CPU_ADDR_MASK;
        region    = masked[15:12];
        rel       = region - REGION_BASE;
        in_window = (region >= REGION_BASE) && (32'(rel) < NUM_PAIRS);
        offs      = {masked[7:6], masked[3:0]};
        odd_sel   = 1'b0;
        nib_raw   = NIB_NONE;
        case (offs)
            6'b00_0000:                         begin odd_sel = 1'b0; nib_raw = NIB_LOW;  end
            6'b00_0010, 6'b01_0000:             begin odd_sel = 1'b0; nib_raw = NIB_HIGH; end
            6'b00_0001, 6'b00_0100, 6'b10_0000: begin odd_sel = 1'b1; nib_raw = NIB_LOW;  end
            6'b00_0011, 6'b00_0110, 6'b11_0000: begin odd_sel = 1'b1; nib_raw = NIB_HIGH; end
            default:                            begin odd_sel = 1'b0; nib_raw = NIB_NONE; end
        endcase
        wr_idx = {rel[SEL_W-2:0], odd_sel};
        wr_nib = (cpu_we && in_window) ? nib_raw : NIB_NONE;
    end

    // R3: a decoded hit only ever comes from an enabled write inside the register window
    always_comb begin
        if (wr_nib != NIB_NONE) begin
            assert_decode_window_R3: assert (cpu_we && cpu_addr[15:12] >= REGION_BASE
                                             && cpu_addr[15:12] < REGION_BASE + 4'(NUM_PAIRS));
        end
    end

endmodule

// File: rtl/chrbank_regfile.sv
module chrbank_regfile
    import chrbank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [$clog2(NUM_BANKS)-1:0]         wr_idx,
    input  nib_sel_e                             wr_nib,
    input  logic [BANK_W-1:0]                    wr_data,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]     bank
);

    localparam int NIB_W = BANK_W / 2;
    localparam int SEL_W = $clog2(NUM_BANKS);

    typedef struct packed {
        logic [NUM_BANKS-1:0][BANK_W-1:0] bank;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (wr_nib)
            NIB_LOW:  st_d.bank[wr_idx][NIB_W-1:0]      = wr_data[NIB_W-1:0];
            NIB_HIGH: st_d.bank[wr_idx][BANK_W-1:NIB_W] = wr_data[NIB_W-1:0];
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_BANKS; k++) begin
                st_q.bank[k] <= BANK_W'(k);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign bank = st_q.bank;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
        // R8: registers not addressed keep their value
        assert_hold_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_nib != NIB_NONE && wr_idx == SEL_W'(g)) |=> $stable(st_q.bank[g]));

        // R4 / R6: low-half write keeps the high half, stores data[3:0]
        assert_low_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_nib == NIB_LOW && wr_idx == SEL_W'(g)) |=>
                (st_q.bank[g][BANK_W-1:NIB_W] == $past(st_q.bank[g][BANK_W-1:NIB_W])
                 && st_q.bank[g][NIB_W-1:0] == $past(wr_data[NIB_W-1:0])));

        // R5 / R7: high-half write keeps the low half, stores data[3:0]
        assert_high_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_nib == NIB_HIGH && wr_idx == SEL_W'(g)) |=>
                (st_q.bank[g][NIB_W-1:0] == $past(st_q.bank[g][NIB_W-1:0])
                 && st_q.bank[g][BANK_W-1:NIB_W] == $past(wr_data[NIB_W-1:0])));
    end

endmodule

// File: rtl/chrbank_lookup.sv
module chrbank_lookup #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8,
    parameter int PAGE_W    = 10
) (
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]        bank,
    input  logic [$clog2(NUM_BANKS)+PAGE_W-1:0]     vid_addr,
    output logic [BANK_W+PAGE_W-1:0]                chr_addr
);

    localparam int SEL_W = $clog2(NUM_BANKS);

    logic [SEL_W-1:0] sel;

    always_comb begin
        sel      = vid_addr[SEL_W+PAGE_W-1:PAGE_W];
        chr_addr = {bank[sel], vid_addr[PAGE_W-1:0]};
    end

endmodule

// File: rtl/chrbank_top.sv
module chrbank_top
    import chrbank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8,
    parameter int PAGE_W    = 10,
    parameter logic [3:0] REGION_BASE = 4'hB
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cpu_we,
    input  logic [15:0]                            cpu_addr,
    input  logic [BANK_W-1:0]                      cpu_data,
    input  logic [$clog2(NUM_BANKS)+PAGE_W-1:0]    vid_addr,
    output logic [BANK_W+PAGE_W-1:0]               chr_addr
);

    localparam int SEL_W = $clog2(NUM_BANKS);

    logic [SEL_W-1:0]                 wr_idx;
    nib_sel_e                         wr_nib;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank;

    chrbank_decode #(
        .SEL_W       (SEL_W),
        .REGION_BASE (REGION_BASE)
    ) u_decode (
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .wr_idx   (wr_idx),
        .wr_nib   (wr_nib)
    );

    chrbank_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_idx  (wr_idx),
        .wr_nib  (wr_nib),
        .wr_data (cpu_data),
        .bank    (bank)
    );

    chrbank_lookup #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .PAGE_W    (PAGE_W)
    ) u_lookup (
        .bank     (bank),
        .vid_addr (vid_addr),
        .chr_addr (chr_addr)
    );

endmodule

// File: tb/sim_chrbank_top.sv
`timescale 1ns/1ps
module sim_chrbank_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_data = 8'h0;
    logic [12:0] vid_addr = 13'h0;
    logic [17:0] chr_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;
    logic [7:0] model [8];

    always #2.5 clk = ~clk;

    chrbank_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .vid_addr(vid_addr), .chr_addr(chr_addr)
    );

    // expected target: -1 when no register is written, else bank*2 + (high half ? 1 : 0)
    function automatic int expect_target(input logic [15:0] a);
        logic [15:0] m;
        int pair;
        int bank_lo;
        m = a & 16'hF0CF;
        if (m[15:12] < 4'hB || m[15:12] > 4'hE) return -1;
        pair = int'(m[15:12]) - 11;
        case (m[11:0])
            12'h000:                   bank_lo = 0;
            12'h002, 12'h040:          bank_lo = 1;
            12'h001, 12'h004, 12'h080: bank_lo = 2;
            12'h003, 12'h006, 12'h0C0: bank_lo = 3;
            default:                   return -1;
        endcase
        return (pair * 2 + bank_lo / 2) * 2 + (bank_lo % 2);
    endfunction

    task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: chr_addr=%h expected=%h (vid_addr=%h)", tag, got, exp, vid_addr);
        end
    endtask

    task automatic check_all(input string tgt_tag, input int tgt_bank, input logic [9:0] low);
        for (int b = 0; b < 8; b++) begin
            vid_addr = {b[2:0], low};
            #0.25;
            check((b == tgt_bank) ? tgt_tag : ((tgt_bank < 0) ? "R9" : "R8"),
                  chr_addr, {model[b], low});
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [9:0] low);
        int t;
        string tag;
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
        #0.25;
        // R10: nothing visible before the edge
        for (int b = 0; b < 8; b++) begin
            vid_addr = {b[2:0], low};
            #0.2;
            check("R10", chr_addr, {model[b], low});
        end
        @(negedge clk);
        cpu_we = 1'b0;
        t = expect_target(a);
        if (t >= 0) begin
            if (t % 2 == 1) model[t/2][7:4] = d[3:0];
            else            model[t/2][3:0] = d[3:0];
        end
        case (t < 0 ? -1 : ((t / 2) % 2) * 2 + (t % 2))
            0:       tag = "R4";
            1:       tag = "R5";
            2:       tag = "R6";
            3:       tag = "R7";
            default: tag = "R9";
        endcase
        check_all(tag, t < 0 ? -1 : t / 2, low);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_fail++;
                $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = 8'(k);
        repeat (3) @(negedge clk);
        // R1: reset values visible during reset
        check_all("R1", 0, 10'h000);
        rst_n = 1'b1;
        // R1, R2: full video-address sweep after reset
        for (int v = 0; v < 8192; v++) begin
            @(negedge clk);
            vid_addr = 13'(v);
            #0.5;
            check((v % 1024 == 0) ? "R1" : "R2", chr_addr, {8'(v / 1024), 10'(v % 1024)});
        end
        // R10: strobe low at a valid alias
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 16'hB000; cpu_data = 8'h5A;
        @(negedge clk);
        check_all("R10", 0, 10'h155);
        // R3..R9: sweep of every low byte in every top-nibble region, masked bits varied
        for (int r = 0; r < 16; r++) begin
            for (int lb = 0; lb < 256; lb++) begin
                logic [15:0] a;
                logic [7:0]  d;
                a = {4'(r), 4'(lb) ^ 4'(r), 8'(lb)};
                d = 8'(lb * 29 + r * 11 + 1);
                do_write(a, d, 10'(lb * 37 + r));
            end
        end
        // R3, R8: plain-address writes of full bytes then readback
        for (int b = 0; b < 8; b++) begin
            logic [15:0] base;
            base = {4'(11 + b / 2), 12'h000};
            do_write(base | ((b % 2 == 1) ? 16'h0001 : 16'h0000), 8'hF0 | 8'(b), 10'h3FF);
            do_write(base | ((b % 2 == 1) ? 16'h0003 : 16'h0002), 8'h90 | 8'(7 - b), 10'h001);
        end
        check_all("R3", -1, 10'h2AA);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule